// File: doc/BRIEF.md
# Execution Stall Cycle Classifier

This block is a set of performance counters for a core with one matrix pipeline and a parameterised number of vector pipelines. On every clock it samples the empty flag of each pipeline and the opcode at the head of each vector pipeline. It also samples the empty flag and head opcode of the queue of execution work still waiting to issue, plus a core-running flag. From these it decides what kind of cycle it was: memory-bound (nothing computing), matrix-busy or vector-busy. It then bumps the matching counters, including per-operation breakdowns.

A memory-bound cycle is charged to the operation waiting at the head of the execution queue. If that queue is empty, the cycle counts as store-phase time. In a vector-busy cycle every non-empty vector pipeline charges one cycle to the counter for its own head operation, so several counters can move in the same cycle. A separate counter records cycles in which the core is not running, independent of the other classes.

All counters saturate instead of wrapping and are cleared by the synchronous reset. Software or a debug path reads them through an index input, and the selected value appears on a registered output one cycle later.

Top module: `stall_classifier`

## Requirements
- R1: A cycle is idle when the matrix pipeline and every vector pipeline are empty. Each idle cycle adds one to counter 0. A non-idle cycle leaves counter 0 unchanged.
- R2: In an idle cycle, counter 1 (store phase) increments if the execution queue is empty. Otherwise counter 2 (load phase) increments.
- R3: Opcodes are 3 bits wide. In an idle cycle with a non-empty queue, a head opcode of 0 (matrix multiply) or 1 (matrix multiply with weight preload) increments counter 3. No other opcode touches counter 3.
- R4: In an idle cycle with a non-empty queue, head opcodes 2 (layer norm), 3 (softmax), 4 (add) and 5 (GELU) increment counters 4, 5, 6 and 7 respectively. Opcodes 6 and 7 increment none of counters 3 to 7.
- R5: In a non-idle cycle with the matrix pipeline non-empty, counter 8 increments and the vector-busy counters 9 to 12 stay unchanged.
- R6: In a non-idle cycle with the matrix pipeline empty, each non-empty vector pipeline adds one to counter 9, 10, 11 or 12 when its head opcode is 2, 3, 4 or 5 respectively. Several pipelines can add to the same counter in one cycle. Empty pipelines and opcodes 0, 1, 6 and 7 add nothing.
- R7: Counter 13 increments in every cycle in which the core-running input is low, whatever else happens in that cycle.
- R8: Every counter saturates at its all-ones value; an increment that would pass it leaves the counter at all ones.
- R9: rd_data shows the counter selected by rd_idx. It is registered one cycle after rd_idx and holds the counter's value from before that clock edge's update. An index of 14 or 15 reads zero.
- R10: While rst is high at a clock edge, all counters and rd_data are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mx_empty | input | 1 | Matrix pipeline is empty |
| vp_empty | input | NVP | Empty flag per vector pipeline |
| vp_op | input | 3*NVP | Head opcode per vector pipeline, pipeline p in bits [3p+2:3p] |
| eq_empty | input | 1 | Execution queue is empty |
| eq_op | input | 3 | Opcode at the head of the execution queue |
| core_run | input | 1 | Core is running |
| rd_idx | input | 4 | Counter index to read |
| rd_data | output | CNT_W | Registered value of the selected counter |

## Verification
The counters update at the first clock edge after the classification inputs are applied. A read of index k issued at the same time returns, one edge later, the value counter k held before that update. The bench drives each stimulus on a falling edge and records the expected read value from its own model at that moment. It then applies the model's increments once the rising edge has passed and compares rd_data on the next falling edge, so every comparison falls exactly one register stage after its index. Saturation is reached by shrinking the counter width in the bench and running long idle bursts.

// File: rtl/stall_cls_pkg.sv
package stall_cls_pkg;
  localparam int OP_W   = 3;
  localparam int NCNT   = 14;
  localparam int IDX_W  = 4;

  // opcode encoding
  localparam logic [OP_W-1:0] OP_MM      = 3'd0;
  localparam logic [OP_W-1:0] OP_MM_PRE  = 3'd1;
  localparam logic [OP_W-1:0] OP_LNORM   = 3'd2;
  localparam logic [OP_W-1:0] OP_SMAX    = 3'd3;
  localparam logic [OP_W-1:0] OP_ADD     = 3'd4;
  localparam logic [OP_W-1:0] OP_GELU    = 3'd5;

  // counter slots
  localparam int IX_MEM      = 0;
  localparam int IX_STORE    = 1;
  localparam int IX_LOAD     = 2;
  localparam int IX_STL_MM   = 3;
  localparam int IX_STL_LN   = 4;
  localparam int IX_STL_SM   = 5;
  localparam int IX_STL_ADD  = 6;
  localparam int IX_STL_GELU = 7;
  localparam int IX_MATMUL   = 8;
  localparam int IX_VB_LN    = 9;
  localparam int IX_VB_SM    = 10;
  localparam int IX_VB_ADD   = 11;
  localparam int IX_VB_GELU  = 12;
  localparam int IX_NOTRUN   = 13;
endpackage

// File: rtl/stall_cls_decode.sv
module stall_cls_decode
  import stall_cls_pkg::*;
#(
  parameter int NVP   = 4,
  parameter int INC_W = $clog2(NVP + 1)
) (
  input  logic                          mx_empty,
  input  logic [NVP-1:0]                vp_empty,
  input  logic [NVP*OP_W-1:0]           vp_op,
  input  logic                          eq_empty,
  input  logic [OP_W-1:0]               eq_op,
  input  logic                          core_run,
  output logic [NCNT-1:0][INC_W-1:0]    inc
);
  logic idle;
  assign idle = mx_empty & (&vp_empty);

  always_comb begin
    inc = '0;
    if (idle) begin
      inc[IX_MEM] = INC_W'(1);
      if (eq_empty) begin
        inc[IX_STORE] = INC_W'(1);
      end else begin
        inc[IX_LOAD] = INC_W'(1);
        case (eq_op)
          OP_MM, OP_MM_PRE: inc[IX_STL_MM]   = INC_W'(1);
          OP_LNORM:         inc[IX_STL_LN]   = INC_W'(1);
          OP_SMAX:          inc[IX_STL_SM]   = INC_W'(1);
          OP_ADD:           inc[IX_STL_ADD]  = INC_W'(1);
          OP_GELU:          inc[IX_STL_GELU] = INC_W'(1);
          default: ;
        endcase
      end
    end else if (!mx_empty) begin
      inc[IX_MATMUL] = INC_W'(1);
    end else begin
      for (int p = 0; p < NVP; p++) begin
        if (!vp_empty[p]) begin
          case (vp_op[p*OP_W +: OP_W])
            OP_LNORM: inc[IX_VB_LN]   = inc[IX_VB_LN]   + INC_W'(1);
            OP_SMAX:  inc[IX_VB_SM]   = inc[IX_VB_SM]   + INC_W'(1);
            OP_ADD:   inc[IX_VB_ADD]  = inc[IX_VB_ADD]  + INC_W'(1);
            OP_GELU:  inc[IX_VB_GELU] = inc[IX_VB_GELU] + INC_W'(1);
            default: ;
          endcase
        end
      end
    end
    if (!core_run) inc[IX_NOTRUN] = INC_W'(1);
  end
endmodule

// File: rtl/stall_cls_counter.sv
module stall_cls_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, q} + (CNT_W + 1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (sum[CNT_W]) q <= '1;
    else                q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/stall_cls_rdport.sv
module stall_cls_rdport
  import stall_cls_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic [NCNT-1:0][CNT_W-1:0]    cnt,
  output logic [CNT_W-1:0]              rd_data
);
  localparam int NSLOT = 1 << IDX_W;
  logic [NSLOT-1:0][CNT_W-1:0] slot;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NCNT) begin : g_used
      assign slot[s] = cnt[s];
    end else begin : g_pad
      assign slot[s] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= slot[rd_idx];
  end
endmodule

// File: rtl/stall_classifier.sv
module stall_classifier
  import stall_cls_pkg::*;
#(
  parameter int NVP   = 4,
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mx_empty,
  input  logic [NVP-1:0]          vp_empty,
  input  logic [NVP*OP_W-1:0]     vp_op,
  input  logic                    eq_empty,
  input  logic [OP_W-1:0]         eq_op,
  input  logic                    core_run,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [CNT_W-1:0]        rd_data
);
  localparam int INC_W = $clog2(NVP + 1);

  logic [NCNT-1:0][INC_W-1:0] inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;

  stall_cls_decode #(.NVP(NVP), .INC_W(INC_W)) u_decode (
    .mx_empty (mx_empty),
    .vp_empty (vp_empty),
    .vp_op    (vp_op),
    .eq_empty (eq_empty),
    .eq_op    (eq_op),
    .core_run (core_run),
    .inc      (inc)
  );

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    stall_cls_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (inc[c]),
      .q   (cnt_q[c])
    );
  end

  stall_cls_rdport #(.CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .cnt     (cnt_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/stall_classifier_chk.sv
module stall_classifier_chk
  import stall_cls_pkg::*;
#(
  parameter int NVP   = 4,
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mx_empty,
  input logic [NVP-1:0]             vp_empty,
  input logic [NVP*OP_W-1:0]        vp_op,
  input logic                       eq_empty,
  input logic [OP_W-1:0]            eq_op,
  input logic                       core_run,
  input logic [IDX_W-1:0]           rd_idx,
  input logic [CNT_W-1:0]           rd_data,
  input logic [NCNT-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic idle_c;
  logic any_add;
  assign idle_c = mx_empty && (vp_empty == {NVP{1'b1}});

  always_comb begin
    any_add = 1'b0;
    for (int p = 0; p < NVP; p++)
      if (!vp_empty[p] && vp_op[p*OP_W +: OP_W] == OP_ADD) any_add = 1'b1;
  end

  AST_MEM_STEP: assert property (@(posedge clk) disable iff (rst)
    idle_c && cnt_q[IX_MEM] != MAXV |=> cnt_q[IX_MEM] == $past(cnt_q[IX_MEM]) + 1'b1); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !idle_c |=> $stable(cnt_q[IX_MEM])); // R1
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    eq_empty |=> $stable(cnt_q[IX_LOAD])); // R2
  AST_MMSTALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    eq_op != OP_MM && eq_op != OP_MM_PRE |=> $stable(cnt_q[IX_STL_MM])); // R3
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mx_empty |=> $stable(cnt_q[IX_VB_LN])); // R5
  AST_ADD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_add |=> $stable(cnt_q[IX_VB_ADD])); // R6
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    core_run |=> $stable(cnt_q[IX_NOTRUN])); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q[IX_MEM] == MAXV |=> cnt_q[IX_MEM] == MAXV); // R8
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_idx >= IDX_W'(NCNT) |=> rd_data == '0); // R9
endmodule

bind stall_classifier stall_classifier_chk #(.NVP(NVP), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mx_empty (mx_empty),
  .vp_empty (vp_empty),
  .vp_op    (vp_op),
  .eq_empty (eq_empty),
  .eq_op    (eq_op),
  .core_run (core_run),
  .rd_idx   (rd_idx),
  .rd_data  (rd_data),
  .cnt_q    (cnt_q)
);

// File: tb/stall_classifier_tb.sv
`timescale 1ns/1ps
module stall_classifier_tb_top;
  localparam int NVP   = 3;
  localparam int CNT_W = 10;
  localparam int NC    = 14;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mx_empty = 1'b1;
  logic [NVP-1:0]   vp_empty = '1;
  logic [NVP*3-1:0] vp_op = '0;
  logic             eq_empty = 1'b1;
  logic [2:0]       eq_op = '0;
  logic             core_run = 1'b1;
  logic [3:0]       rd_idx = '0;
  logic [CNT_W-1:0] rd_data;

  int unsigned mdl [NC];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  stall_classifier #(.NVP(NVP), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .mx_empty(mx_empty), .vp_empty(vp_empty), .vp_op(vp_op),
    .eq_empty(eq_empty), .eq_op(eq_op), .core_run(core_run), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic string tag_of(int idx, int unsigned expv);
    if (expv == MAXV) return "R8";
    if (idx == 0) return "R1";
    if (idx <= 2) return "R2";
    if (idx == 3) return "R3";
    if (idx <= 7) return "R4";
    if (idx == 8) return "R5";
    if (idx <= 12) return "R6";
    if (idx == 13) return "R7";
    return "R9";
  endfunction

  function automatic int stall_slot(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 3;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic bump(int k, int unsigned n);
    if (mdl[k] + n > MAXV) mdl[k] = MAXV;
    else mdl[k] = mdl[k] + n;
  endtask

  task automatic model_update();
    int unsigned vb [4];
    foreach (vb[i]) vb[i] = 0;
    if (mx_empty && vp_empty == '1) begin
      bump(0, 1);
      if (eq_empty) bump(1, 1);
      else begin
        bump(2, 1);
        if (stall_slot(eq_op) >= 0) bump(stall_slot(eq_op), 1);
      end
    end else if (!mx_empty) begin
      bump(8, 1);
    end else begin
      for (int p = 0; p < NVP; p++) begin
        logic [2:0] op;
        op = vp_op[p*3 +: 3];
        if (!vp_empty[p] && op >= 3'd2 && op <= 3'd5) vb[op - 2] = vb[op - 2] + 1;
      end
      for (int i = 0; i < 4; i++) bump(9 + i, vb[i]);
    end
    if (!core_run) bump(13, 1);
  endtask

  // called on a falling edge
  task automatic step(input logic mxe, input logic [NVP-1:0] vpe, input logic [NVP*3-1:0] vop,
                      input logic eqe, input logic [2:0] eqo, input logic run, input logic [3:0] idx);
    int unsigned expv;
    mx_empty = mxe; vp_empty = vpe; vp_op = vop;
    eq_empty = eqe; eq_op = eqo; core_run = run; rd_idx = idx;
    expv = (idx < NC) ? mdl[idx] : 0;
    @(posedge clk);
    model_update();
    @(negedge clk);
    n_chk++;
    if (rd_data !== CNT_W'(expv)) begin
      n_bad++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag_of(idx, expv), idx, rd_data, expv);
    end
  endtask

  // quiet: vectors busy with opcode 7, running -> no counter moves
  task automatic read_quiet(input logic [3:0] idx);
    step(1'b1, '0, {NVP{3'd7}}, 1'b1, 3'd0, 1'b1, idx);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (mdl[i]) mdl[i] = 0;
    rd_idx = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (rd_data !== '0) begin
      n_bad++;
      $display("FAIL R10 reset rd_data actual=%0d expected=0", rd_data);
    end
    rst = 1'b0;
    // R10: all counters zero after reset, including pad slots (R9)
    for (int i = 0; i < 16; i++) read_quiet(4'(i));

    // R1/R2: idle with empty queue
    step(1'b1, '1, '0, 1'b1, 3'd0, 1'b1, 4'd0);
    read_quiet(4'd1);
    // R3: preload opcode stalls
    step(1'b1, '1, '0, 1'b0, 3'd1, 1'b1, 4'd3);
    read_quiet(4'd3);
    // R4: each stall opcode, then opcode 6
    for (int o = 2; o <= 6; o++) step(1'b1, '1, '0, 1'b0, 3'(o), 1'b1, 4'd2);
    for (int i = 2; i <= 7; i++) read_quiet(4'(i));
    // R5: matrix busy with vectors on add
    step(1'b0, '0, {NVP{3'd4}}, 1'b0, 3'd2, 1'b1, 4'd8);
    read_quiet(4'd8);
    read_quiet(4'd11);
    // R6: all three on add, then one empty pipe carrying add
    step(1'b1, 3'b000, {3'd4, 3'd4, 3'd4}, 1'b1, 3'd0, 1'b1, 4'd11);
    step(1'b1, 3'b100, {3'd4, 3'd2, 3'd5}, 1'b1, 3'd0, 1'b1, 4'd11);
    for (int i = 9; i <= 12; i++) read_quiet(4'(i));
    // R7: not running while matrix busy
    step(1'b0, '0, '0, 1'b1, 3'd0, 1'b0, 4'd13);
    read_quiet(4'd13);
    read_quiet(4'd8);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic mxe;
      logic [NVP-1:0] vpe;
      mxe = ($urandom % 3) != 0;
      vpe = ($urandom % 2) ? '1 : NVP'($urandom);
      step(mxe, vpe, (NVP*3)'($urandom), 1'($urandom), 3'($urandom),
           ($urandom % 4) != 0, 4'($urandom));
    end

    // R8: long idle burst drives memory and store counters to saturation
    for (int n = 0; n < 1100; n++) step(1'b1, '1, '0, 1'b1, 3'd0, 1'b0, 4'd0);
    for (int i = 0; i < 16; i++) read_quiet(4'(i));
    // R8: three-at-once vector increments near the top
    for (int n = 0; n < 400; n++) step(1'b1, 3'b000, {3'd3, 3'd3, 3'd3}, 1'b1, 3'd0, 1'b1, 4'd10);
    read_quiet(4'd10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule